// File: doc/BRIEF.md
# Nine-Bit Serial Display Framer

This block sits between a byte producer and a display controller that takes its commands and pixel data over a three-wire serial link. Every byte the producer hands over goes out as one 9-bit word: a flag bit that tells command from data, then the eight payload bits. Words are packed back to back on the serial line, with no idle bits between them and no byte alignment.

A producer offers bytes through a valid/ready handshake. Each byte carries a command flag, and the last byte of a burst is marked. The block raises the chip select when it accepts the first byte of a burst. It then shifts out the words on a serial clock that idles low, with data changing while the clock is low (SPI mode 0). When the marked byte has gone out, it appends whole filler command words until the number of bits in the burst is a multiple of eight. Only then does it release the chip select, so a bus master that counts in bytes always sees a whole number of bytes. The filler opcode is a parameter. Its default is the controller's write-memory command, which leaves the display state unchanged.

The serial clock comes from the system clock through a simple divider. The number of system cycles in each half of a serial clock period is a parameter. A single command transaction from the producer is expected to hold at most 16 bytes: one command byte and up to 15 data bytes.

Top module: `nbit_disp_framer`

## Requirements
- R1: Each accepted byte is sent as a 9-bit word: the flag bit first, then payload bit 7 down to bit 0, one bit per rising edge of `ser_clk`.
- R2: The flag bit is 0 when `src_is_cmd` was 1 for the byte (command), and 1 when it was 0 (data).
- R3: Within a burst, consecutive words follow each other on `ser_clk` with no extra rising edges between them, even when the producer leaves idle cycles between bytes.
- R4: After the word of the byte marked `src_last`, the block appends filler words until the total number of bits in the burst is a multiple of 8. For a burst of n bytes this takes (8 - n mod 8) mod 8 words, so never more than 7.
- R5: A filler word has flag bit 0 and payload `PAD_OPCODE`, whose default is 8'h5C.
- R6: `ser_clk` is low whenever `ser_cs_n` is high, and `ser_dout` does not change while `ser_clk` is high.
- R7: Every high phase of `ser_clk` lasts exactly `HALF_DIV` system clock cycles, and so does the low phase before each rising edge.
- R8: `ser_cs_n` falls only in the cycle after a byte is accepted from idle. It stays low for the whole burst, including the filler words, and it is low at every rising edge of `ser_clk`.
- R9: `src_ready` is low while a word is shifting. It is high in idle, and between the words of a burst once the previous word has finished, which is 18*`HALF_DIV` cycles after that word was accepted.
- R10: `busy` is high from the cycle after the first byte is accepted until `ser_cs_n` returns high, and it always equals the inverse of `ser_cs_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | Producer offers a byte |
| src_ready | output | 1 | Block can take a byte in this cycle |
| src_byte | input | 8 | Byte to send |
| src_is_cmd | input | 1 | 1 = command byte, 0 = data byte |
| src_last | input | 1 | Byte closes the burst |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_dout | output | 1 | Serial data, changes while ser_clk is low |
| ser_cs_n | output | 1 | Active-low chip select |
| busy | output | 1 | Burst in progress |

## Verification
The bench sweeps every burst length from 1 to 16 bytes under three command/data patterns. It rebuilds the expected bit stream arithmetically, including the (8 - n mod 8) mod 8 filler words, and compares every captured bit. This sweep targets the padding arithmetic: a design that counts the modulo wrongly, pads with part-words, or pads a burst that is already aligned would send the wrong number of bits for some length. Bursts with idle gaps between bytes target the word joins: a design that emits clock edges while waiting for the producer would insert gap bits. The bench also measures how long `src_ready` stays low after each byte and how long each serial clock pulse lasts, which exposes off-by-one errors in the divider or the bit counter.

// File: rtl/nbit_disp_framer_pkg.sv
// Shared types for the nine-bit display framer.
package nbit_disp_framer_pkg;

    // Sequencer states: idle, low and high serial-clock phases, and the
    // inter-word wait inside a burst.
    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_LOW  = 2'd1,
        FR_HIGH = 2'd2,
        FR_WAIT = 2'd3
    } fr_state_t;

    localparam int unsigned WORD_BITS = 9;

endpackage

// File: rtl/nbit_half_timer.sv
// Half-period timer for the serial clock.
// Counts system cycles while run is high and pulses tick on the last
// cycle of each half period. Assumes HALF_DIV >= 1. It restarts from zero
// whenever run is low, so a phase always begins with a fresh count.
module nbit_half_timer #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    // Count cycles within one half period and wrap on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == LAST);
endmodule

// File: rtl/nbit_word_shifter.sv
// Nine-bit word shift register.
// Loads a flag+payload word and moves it out MSB first, one bit per shift
// pulse. at_last is high while the final bit of the word is on the line.
// Assumes load and shift are never high together.
module nbit_word_shifter
    import nbit_disp_framer_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [WORD_BITS-1:0] load_word,
    input  logic                 shift,
    output logic                 dout,
    output logic                 at_last
);
    localparam int unsigned IW = $clog2(WORD_BITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(WORD_BITS - 1);

    logic [WORD_BITS-1:0] sreg;
    logic [IW-1:0]        idx;

    // Hold the word in flight and step to the next bit on each shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            idx  <= '0;
        end else if (load) begin
            sreg <= load_word;
            idx  <= '0;
        end else if (shift) begin
            sreg <= {sreg[WORD_BITS-2:0], 1'b0};
            idx  <= idx + 1'b1;
        end
    end

    assign dout    = sreg[WORD_BITS-1];
    assign at_last = (idx == LAST_IDX);
endmodule

// File: rtl/nbit_align_counter.sv
// Burst bit counter, modulo ALIGN.
// Counts the bits sent in the current burst. wrap_next says that the next
// counted bit completes a multiple of ALIGN. Assumes ALIGN is a power of
// two and at least 2.
module nbit_align_counter #(
    parameter int unsigned ALIGN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic wrap_next
);
    localparam int unsigned AW = $clog2(ALIGN);
    localparam logic [AW-1:0] TOP = AW'(ALIGN - 1);

    logic [AW-1:0] cnt;

    // Track the burst bit count modulo the alignment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign wrap_next = (cnt == TOP);
endmodule

// File: rtl/nbit_disp_framer.sv
// Nine-bit display serial framer (top).
// Accepts bytes on a valid/ready port and sends each one as a flag bit plus
// eight payload bits on a mode-0 serial link. At the end of a burst it
// appends filler command words until the bit count is a multiple of 8,
// then releases chip select. Assumes the producer holds its byte stable
// while src_valid is high.
module nbit_disp_framer
    import nbit_disp_framer_pkg::*;
#(
    parameter int unsigned HALF_DIV   = 4,
    parameter logic [7:0]  PAD_OPCODE = 8'h5C,
    parameter int unsigned ALIGN      = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_valid,
    output logic       src_ready,
    input  logic [7:0] src_byte,
    input  logic       src_is_cmd,
    input  logic       src_last,
    output logic       ser_clk,
    output logic       ser_dout,
    output logic       ser_cs_n,
    output logic       busy
);
    fr_state_t            state, state_nx;
    logic                 accept;
    logic                 tick;
    logic                 at_last;
    logic                 wrap_next;
    logic                 last_q;
    logic                 word_end;
    logic                 pad_load;
    logic                 do_load;
    logic                 do_shift;
    logic [WORD_BITS-1:0] word_in;

    assign src_ready = (state == FR_IDLE) || (state == FR_WAIT);
    assign accept    = src_valid && src_ready;
    assign word_end  = (state == FR_HIGH) && tick && at_last;
    assign pad_load  = word_end && last_q && !wrap_next;
    assign do_load   = accept || pad_load;
    assign do_shift  = (state == FR_HIGH) && tick && !at_last;
    assign word_in   = accept ? {~src_is_cmd, src_byte} : {1'b0, PAD_OPCODE};

    nbit_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((state == FR_LOW) || (state == FR_HIGH)),
        .tick  (tick)
    );

    nbit_word_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (do_load),
        .load_word (word_in),
        .shift     (do_shift),
        .dout      (ser_dout),
        .at_last   (at_last)
    );

    nbit_align_counter #(.ALIGN(ALIGN)) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept && (state == FR_IDLE)),
        .inc       ((state == FR_HIGH) && tick),
        .wrap_next (wrap_next)
    );

    // Remember whether the byte in flight closes the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else if (accept) begin
            last_q <= src_last;
        end
    end

    // Choose the next phase of the sequencer.
    always_comb begin
        state_nx = state;
        unique case (state)
            FR_IDLE: if (accept) state_nx = FR_LOW;
            FR_LOW:  if (tick)   state_nx = FR_HIGH;
            FR_HIGH: begin
                if (tick) begin
                    if (!at_last)      state_nx = FR_LOW;
                    else if (!last_q)  state_nx = FR_WAIT;
                    else if (wrap_next) state_nx = FR_IDLE;
                    else               state_nx = FR_LOW;
                end
            end
            FR_WAIT: if (accept) state_nx = FR_LOW;
            default: state_nx = FR_IDLE;
        endcase
    end

    // Register the sequencer state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FR_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    assign ser_clk  = (state == FR_HIGH);
    assign ser_cs_n = (state == FR_IDLE);
    assign busy     = (state != FR_IDLE);
endmodule

// File: rtl/nbit_disp_framer_chk.sv
// Protocol checker for the nine-bit display framer, bound to the top.
// Watches only the ports and keeps its own count of serial clock rises.
module nbit_disp_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic src_valid,
    input logic src_ready,
    input logic ser_clk,
    input logic ser_dout,
    input logic ser_cs_n,
    input logic busy
);
    logic       sclk_q;
    logic [2:0] rise_cnt;

    // Count serial clock rises within a burst, modulo 8.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b0;
            rise_cnt <= '0;
        end else begin
            sclk_q <= ser_clk;
            if (ser_cs_n && !$rose(ser_cs_n)) begin
                rise_cnt <= '0;
            end else if (ser_clk && !sclk_q) begin
                rise_cnt <= rise_cnt + 1'b1;
            end
        end
    end

    assert_clk_idle_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_cs_n |-> !ser_clk);

    assert_dout_stable_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dout));

    assert_ready_low_shifting_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> !src_ready);

    assert_pad_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_cs_n) |-> (rise_cnt == 3'd0));

    assert_cs_falls_on_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_cs_n) |-> $past(src_valid && src_ready));

    assert_busy_vs_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !ser_cs_n);
endmodule

bind nbit_disp_framer nbit_disp_framer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .ser_clk   (ser_clk),
    .ser_dout  (ser_dout),
    .ser_cs_n  (ser_cs_n),
    .busy      (busy)
);

// File: tb/sim_nbit_disp_framer.sv
// Bench: sweeps burst lengths 1..16 under three flag patterns and compares
// the captured serial stream with one built arithmetically.
module sim_nbit_disp_framer;
    localparam int unsigned D    = 2;
    localparam logic [7:0]  FILL = 8'h5C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_valid = 1'b0;
    logic       src_ready;
    logic [7:0] src_byte = '0;
    logic       src_is_cmd = 1'b0;
    logic       src_last = 1'b0;
    logic       ser_clk, ser_dout, ser_cs_n, busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic exp_bits [0:511];
    logic rx_bits  [0:511];
    int   exp_n, rx_n;
    int   ready_err, cs_err, width_err, busy_err, cs_rises, hi_len;
    bit   mon_on = 1'b0;

    nbit_disp_framer #(.HALF_DIV(D)) u0 (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
        .src_byte(src_byte), .src_is_cmd(src_is_cmd), .src_last(src_last),
        .ser_clk(ser_clk), .ser_dout(ser_dout), .ser_cs_n(ser_cs_n), .busy(busy)
    );

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Capture each bit on the serial clock's rising edge (R1, R8, R9).
    always @(posedge ser_clk) begin
        if (rx_n < 512) rx_bits[rx_n] = ser_dout;
        rx_n++;
        if (src_ready) ready_err++;
        if (ser_cs_n) cs_err++;
    end

    always @(posedge ser_cs_n) if (mon_on) cs_rises++;

    // Measure high phases and busy against chip select (R7, R10).
    always @(negedge clk) begin
        if (mon_on) begin
            if (busy !== !ser_cs_n) busy_err++;
            if (ser_clk) hi_len++;
            else if (hi_len != 0) begin
                if (hi_len != D) width_err++;
                hi_len = 0;
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic push_word(input logic flag, input logic [7:0] b);
        exp_bits[exp_n] = flag;
        exp_n++;
        for (int k = 7; k >= 0; k--) begin
            exp_bits[exp_n] = b[k];
            exp_n++;
        end
    endtask

    task automatic run_burst(input int n, input int pat);
        int lowcnt, mism, pads;
        logic cmd;
        logic [7:0] b;
        exp_n = 0; rx_n = 0; ready_err = 0; cs_err = 0; width_err = 0;
        busy_err = 0; cs_rises = 0; hi_len = 0;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            cmd = (pat == 0) ? (i == 0) : (pat == 1) ? 1'b0 : (i % 2 == 0);
            b = 8'((n * 37 + i * 11 + pat * 101) & 255);
            if (pat == 1 && i == 0) b = 8'hFF;
            if (pat == 2 && i == 1) b = 8'h00;
            push_word(~cmd, b);
            if (pat == 2) repeat (i % 3) @(negedge clk);
            src_valid = 1'b1; src_byte = b; src_is_cmd = cmd; src_last = (i == n - 1);
            @(posedge clk);
            @(negedge clk);
            src_valid = 1'b0;
            if (i != n - 1) begin
                lowcnt = 0;
                while (!src_ready) begin
                    lowcnt++;
                    @(negedge clk);
                end
                chk(lowcnt == 18 * D, "R9 ready returns after word", lowcnt, 18 * D);
            end
        end
        pads = (8 - n % 8) % 8;
        for (int j = 0; j < pads; j++) push_word(1'b0, FILL);
        while (!ser_cs_n) @(negedge clk);
        repeat (3) @(negedge clk);
        mism = 0;
        for (int k = 0; k < exp_n && k < rx_n; k++)
            if (rx_bits[k] !== exp_bits[k]) mism++;
        chk(rx_n == exp_n, "R3 R4 bit count incl. padding", rx_n, exp_n);
        chk(mism == 0, "R1 R2 R5 stream content", mism, 0);
        chk(ready_err == 0, "R9 ready low at sclk rise", ready_err, 0);
        chk(cs_err == 0 && cs_rises == 1, "R8 cs held over burst", cs_err * 100 + cs_rises, 1);
        chk(width_err == 0, "R7 high phase width", width_err, 0);
        chk(busy_err == 0, "R10 busy vs cs", busy_err, 0);
        chk(!busy && src_ready && !ser_clk, "R6 R10 idle after burst",
            {busy, src_ready, ser_clk}, 3'b010);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_cs_n == 1'b1, "R8 reset cs high", ser_cs_n, 1);
        chk(ser_clk == 1'b0, "R6 reset sclk low", ser_clk, 0);
        chk(busy == 1'b0, "R10 reset not busy", busy, 0);
        chk(src_ready == 1'b1, "R9 reset ready", src_ready, 1);
        mon_on = 1'b1;
        for (int pat = 0; pat < 3; pat++)
            for (int n = 1; n <= 16; n++)
                run_burst(n, pat);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule